// File: doc/BRIEF.md
# Input Port Power Gating Controller

This unit sits beside one router and decides, port by port, when an input port may be powered down. Each input port has its own counter of consecutive cycles without traffic. Once that run exceeds a programmable limit, the port's power enable drops. The port is then reported to route computation as busy, so no neighbour is granted a path into it. A flit or a wake request arriving at a gated port starts a wake sequence of configurable length. Only when that sequence ends does the port report itself ready again.

At router level, the controller drops a clock enable for the whole router when every input port is off and the router's buffers report empty. A wake request on any input raises that enable again in the same cycle, without waiting for a clock edge. The controller itself runs in an always-on domain.

On the output side, when route computation needs an output whose neighbour input port is not ready, the controller raises a wake request toward that neighbour. It marks the output free only one cycle after the neighbour reports ready; that extra cycle is the arbitration cycle.

Top module: `port_power_ctrl`

## Requirements
- R1: While reset is high and at the first edge after it is released, every port is on: port_pwr_en=1, port_ready=1, port_busy=0. Also router_clk_en=1, wake_req_out=0 and out_free=0.
- R2: With idle_limit=L, an on port turns off at the clock edge that samples its (L+1)-th consecutive cycle with flit_in and wake_req_in both low. Turning off drives port_pwr_en=0, port_ready=0 and port_busy=1. The port stays on before that edge.
- R3: A cycle with flit_in or wake_req_in high on an on port restarts that port's idle run from zero. The idle counter never wraps, even with idle_limit at its largest value.
- R4: An off port keeps port_pwr_en=0, port_ready=0 and port_busy=1 for as long as both flit_in and wake_req_in stay low.
- R5: When an off port samples flit_in or wake_req_in high at edge k, port_pwr_en rises at edge k. port_ready rises and port_busy falls at the max(wake_cycles,1)-th edge, counting edge k as the first.
- R6: While a port is waking, further wake requests or flits neither restart nor shorten its wake sequence, and the idle counter does not run.
- R7: router_clk_en is registered low from the edge at which every port's new state is off while router_empty=1. It stays high while router_empty=0 even if all ports are off.
- R8: router_clk_en is high in any cycle in which any wake_req_in bit is high, in the same cycle and without waiting for a clock edge.
- R9: wake_req_out[p] at each edge takes the value route_need[p] & ~nbr_ready[p] sampled at that edge.
- R10: out_free[p] is nbr_ready[p] delayed by one clock edge, which leaves one arbitration cycle after the neighbour becomes ready.
- R11: route_need and nbr_ready have no effect on any input port's state or on its idle count.
- R12: Each input port's idle count, wake sequence and state are independent of every other port's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_limit | input | CNT_W | Idle cycles tolerated before a port is gated |
| wake_cycles | input | WAKE_W | Wake latency of an input port in cycles |
| flit_in | input | N_PORTS | Per input port: a flit arrives this cycle |
| wake_req_in | input | N_PORTS | Per input port: upstream asks for the port to wake |
| router_empty | input | 1 | No flit is held anywhere in the router |
| route_need | input | N_PORTS | Per output: route computation wants this output |
| nbr_ready | input | N_PORTS | Per output: the downstream input port is ready |
| port_pwr_en | output | N_PORTS | Power switch enable of each input port |
| port_ready | output | N_PORTS | Input port is fully on and may accept traffic |
| port_busy | output | N_PORTS | Input port is reported busy to route computation |
| router_clk_en | output | 1 | Whole-router clock and power enable |
| wake_req_out | output | N_PORTS | Wake request toward each downstream port |
| out_free | output | N_PORTS | Output usable by arbitration after neighbour wake |

## Verification
Several properties are checked on every cycle. A powered-down port must look busy and not ready, and a ready port must be powered. A wake request must restore power at the next edge. A gated port must stay gated without stimulus. The router enable must follow wake requests combinationally. The output-side signals must track their one-edge delays, and the router must never be gated while any port keeps power. The exact length of an idle run and of a wake sequence can only be shown by the bench's scenarios. So can the restart of the idle count by traffic, the indifference of a waking port to repeated requests, and the independence of ports. The bench compares each cycle against a reference model built from the requirements, under directed and random traffic.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PS_ON   = 2'd0,
    PS_OFF  = 2'd1,
    PS_WAKE = 2'd2
  } port_st_e;
endpackage

// File: rtl/pg_port_fsm.sv
module pg_port_fsm #(
  parameter int CNT_W  = 16,
  parameter int WAKE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  idle_limit,
  input  logic [WAKE_W-1:0] wake_cycles,
  input  logic              flit,
  input  logic              wake,
  output logic              pwr_en,
  output logic              ready,
  output logic              busy,
  output logic              off_next
);
  import pg_pkg::*;

  port_st_e          st_q, st_n;
  logic [CNT_W-1:0]  idle_q, idle_n;
  logic [WAKE_W-1:0] wcnt_q, wcnt_n;
  logic              activity;
  logic              idle_over;
  logic              wake_done;
  logic              wake_short;

  assign activity   = flit | wake;
  // widened compares: counter cannot wrap even when the limit is all ones
  assign idle_over  = ({1'b0, idle_q} + 1'b1) > {1'b0, idle_limit};
  assign wake_done  = ({1'b0, wcnt_q} + 1'b1) >= {1'b0, wake_cycles};
  assign wake_short = wake_cycles <= WAKE_W'(1);

  always_comb begin
    st_n   = st_q;
    idle_n = idle_q;
    wcnt_n = wcnt_q;
    unique case (st_q)
      PS_ON: begin
        if (activity) begin
          idle_n = '0;
        end else if (idle_over) begin
          st_n   = PS_OFF;
          idle_n = '0;
        end else begin
          idle_n = idle_q + 1'b1;
        end
      end
      PS_OFF: begin
        idle_n = '0;
        if (activity) begin
          if (wake_short) begin
            st_n = PS_ON;
          end else begin
            st_n   = PS_WAKE;
            wcnt_n = WAKE_W'(1);
          end
        end
      end
      PS_WAKE: begin
        idle_n = '0;
        if (wake_done) begin
          st_n = PS_ON;
        end else begin
          wcnt_n = wcnt_q + 1'b1;
        end
      end
      default: begin
        st_n   = PS_ON;
        idle_n = '0;
      end
    endcase
  end

  assign off_next = (st_n == PS_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_ON;
      idle_q <= '0;
      wcnt_q <= '0;
      pwr_en <= 1'b1;
      ready  <= 1'b1;
      busy   <= 1'b0;
    end else begin
      st_q   <= st_n;
      idle_q <= idle_n;
      wcnt_q <= wcnt_n;
      pwr_en <= (st_n != PS_OFF);
      ready  <= (st_n == PS_ON);
      busy   <= (st_n != PS_ON);
    end
  end
endmodule

// File: rtl/pg_out_wake.sv
module pg_out_wake #(
  parameter int N_PORTS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] route_need,
  input  logic [N_PORTS-1:0] nbr_ready,
  output logic [N_PORTS-1:0] wake_req_out,
  output logic [N_PORTS-1:0] out_free
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        wake_req_out[p] <= 1'b0;
        out_free[p]     <= 1'b0;
      end else begin
        wake_req_out[p] <= route_need[p] & ~nbr_ready[p];
        out_free[p]     <= nbr_ready[p];
      end
    end
  end
endmodule

// File: rtl/pg_router_gate.sv
module pg_router_gate #(
  parameter int N_PORTS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] off_next,
  input  logic               router_empty,
  input  logic [N_PORTS-1:0] wake_req_in,
  output logic               router_clk_en
);
  logic on_q;

  always_ff @(posedge clk) begin
    if (rst) on_q <= 1'b1;
    else     on_q <= ~((&off_next) & router_empty);
  end

  assign router_clk_en = on_q | (|wake_req_in);
endmodule

// File: rtl/port_power_ctrl.sv
module port_power_ctrl #(
  parameter int N_PORTS = 5,
  parameter int CNT_W   = 16,
  parameter int WAKE_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   idle_limit,
  input  logic [WAKE_W-1:0]  wake_cycles,
  input  logic [N_PORTS-1:0] flit_in,
  input  logic [N_PORTS-1:0] wake_req_in,
  input  logic               router_empty,
  input  logic [N_PORTS-1:0] route_need,
  input  logic [N_PORTS-1:0] nbr_ready,
  output logic [N_PORTS-1:0] port_pwr_en,
  output logic [N_PORTS-1:0] port_ready,
  output logic [N_PORTS-1:0] port_busy,
  output logic               router_clk_en,
  output logic [N_PORTS-1:0] wake_req_out,
  output logic [N_PORTS-1:0] out_free
);
  logic [N_PORTS-1:0] off_next;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    pg_port_fsm #(.CNT_W(CNT_W), .WAKE_W(WAKE_W)) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .idle_limit (idle_limit),
      .wake_cycles(wake_cycles),
      .flit       (flit_in[p]),
      .wake       (wake_req_in[p]),
      .pwr_en     (port_pwr_en[p]),
      .ready      (port_ready[p]),
      .busy       (port_busy[p]),
      .off_next   (off_next[p])
    );
  end

  pg_router_gate #(.N_PORTS(N_PORTS)) u_gate (
    .clk          (clk),
    .rst          (rst),
    .off_next     (off_next),
    .router_empty (router_empty),
    .wake_req_in  (wake_req_in),
    .router_clk_en(router_clk_en)
  );

  pg_out_wake #(.N_PORTS(N_PORTS)) u_out (
    .clk         (clk),
    .rst         (rst),
    .route_need  (route_need),
    .nbr_ready   (nbr_ready),
    .wake_req_out(wake_req_out),
    .out_free    (out_free)
  );
endmodule

// File: rtl/port_power_ctrl_chk.sv
module port_power_ctrl_chk #(
  parameter int N_PORTS = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PORTS-1:0] flit_in,
  input logic [N_PORTS-1:0] wake_req_in,
  input logic [N_PORTS-1:0] route_need,
  input logic [N_PORTS-1:0] nbr_ready,
  input logic [N_PORTS-1:0] port_pwr_en,
  input logic [N_PORTS-1:0] port_ready,
  input logic [N_PORTS-1:0] port_busy,
  input logic               router_clk_en,
  input logic [N_PORTS-1:0] wake_req_out,
  input logic [N_PORTS-1:0] out_free
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_p
    assert_off_busy_R4: assert property (@(posedge clk) disable iff (rst)
      !port_pwr_en[p] |-> (port_busy[p] && !port_ready[p]));
    assert_ready_powered_R5: assert property (@(posedge clk) disable iff (rst)
      port_ready[p] |-> (port_pwr_en[p] && !port_busy[p]));
    assert_wake_powers_R5: assert property (@(posedge clk) disable iff (rst)
      (!port_pwr_en[p] && (wake_req_in[p] || flit_in[p])) |=> port_pwr_en[p]);
    assert_off_holds_R4: assert property (@(posedge clk) disable iff (rst)
      (!port_pwr_en[p] && !wake_req_in[p] && !flit_in[p]) |=> !port_pwr_en[p]);
    assert_wake_out_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (wake_req_out[p] == $past(route_need[p] & ~nbr_ready[p])));
    assert_free_delay_R10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_free[p] == $past(nbr_ready[p])));
  end

  assert_clk_on_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (|wake_req_in) |-> router_clk_en);
  assert_gated_all_off_R7: assert property (@(posedge clk) disable iff (rst)
    !router_clk_en |-> (port_pwr_en == '0));
endmodule

bind port_power_ctrl port_power_ctrl_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flit_in      (flit_in),
  .wake_req_in  (wake_req_in),
  .route_need   (route_need),
  .nbr_ready    (nbr_ready),
  .port_pwr_en  (port_pwr_en),
  .port_ready   (port_ready),
  .port_busy    (port_busy),
  .router_clk_en(router_clk_en),
  .wake_req_out (wake_req_out),
  .out_free     (out_free)
);

// File: tb/port_power_ctrl_bench.sv
module port_power_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int CW = 16;
  localparam int WW = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst;
  logic [CW-1:0] idle_limit;
  logic [WW-1:0] wake_cycles;
  logic [NP-1:0] flit_in, wake_req_in, route_need, nbr_ready;
  logic          router_empty;
  logic [NP-1:0] port_pwr_en, port_ready, port_busy, wake_req_out, out_free;
  logic          router_clk_en;

  port_power_ctrl #(.N_PORTS(NP), .CNT_W(CW), .WAKE_W(WW)) u_port_power_ctrl (
    .clk(clk), .rst(rst), .idle_limit(idle_limit), .wake_cycles(wake_cycles),
    .flit_in(flit_in), .wake_req_in(wake_req_in), .router_empty(router_empty),
    .route_need(route_need), .nbr_ready(nbr_ready), .port_pwr_en(port_pwr_en),
    .port_ready(port_ready), .port_busy(port_busy), .router_clk_en(router_clk_en),
    .wake_req_out(wake_req_out), .out_free(out_free)
  );

  // reference model: 0 on, 1 off, 2 waking
  int m_st[NP];
  int m_ic[NP];
  int m_wc[NP];
  bit m_rtr;
  bit m_wout[NP];
  bit m_free[NP];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_wake(input int wc);
    return (wc <= 1) ? 1 : wc;
  endfunction

  task automatic model_step();
    bit all_off = 1'b1;
    for (int p = 0; p < NP; p++) begin
      bit act = flit_in[p] | wake_req_in[p];   // R11: route signals ignored
      case (m_st[p])
        0: if (act) m_ic[p] = 0;
           else if (m_ic[p] + 1 > int'(idle_limit)) begin m_st[p] = 1; m_ic[p] = 0; end
           else m_ic[p]++;
        1: if (act) begin
             if (eff_wake(int'(wake_cycles)) == 1) m_st[p] = 0;
             else begin m_st[p] = 2; m_wc[p] = 1; end
           end
        default: if (m_wc[p] + 1 >= int'(wake_cycles)) m_st[p] = 0;
                 else m_wc[p]++;
      endcase
      if (m_st[p] != 1) all_off = 1'b0;
      m_wout[p] = route_need[p] & ~nbr_ready[p];
      m_free[p] = nbr_ready[p];
    end
    m_rtr = !(all_off && router_empty);
  endtask

  task automatic check_all();
    for (int p = 0; p < NP; p++) begin
      chk("R2 R3 R4 R5 R6 R12 port_pwr_en", port_pwr_en[p], m_st[p] != 1);
      chk("R2 R5 port_ready", port_ready[p], m_st[p] == 0);
      chk("R4 R5 port_busy", port_busy[p], m_st[p] != 0);
      chk("R9 wake_req_out", wake_req_out[p], m_wout[p]);
      chk("R10 out_free", out_free[p], m_free[p]);
    end
    chk("R7 router_clk_en", router_clk_en, m_rtr);
  endtask

  // called at a negedge: drive, check the same-cycle enable, then advance
  task automatic cyc(input logic [NP-1:0] f, input logic [NP-1:0] w,
                     input logic [NP-1:0] nd, input logic [NP-1:0] nr,
                     input logic emp);
    flit_in = f; wake_req_in = w; route_need = nd; nbr_ready = nr; router_empty = emp;
    #1;
    chk("R8 router_clk_en same cycle", router_clk_en, m_rtr | (|w));
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; idle_limit = 16'd3; wake_cycles = 3'd2;
    flit_in = '0; wake_req_in = '0; route_need = '0; nbr_ready = '0; router_empty = 1'b1;
    for (int p = 0; p < NP; p++) begin m_st[p] = 0; m_ic[p] = 0; m_wc[p] = 0;
      m_wout[p] = 0; m_free[p] = 0; end
    m_rtr = 1'b1;
    repeat (3) @(negedge clk);
    check_all();                              // R1 during reset
    rst = 1'b0;
    cyc('0, '0, '0, '0, 1'b1);                // R1 first edge after reset: idle count 1

    // R2: limit 3, ports off at 4th idle edge; R7 router gates when empty
    cyc('0, '0, '0, '0, 1'b1);
    cyc('0, '0, '0, '0, 1'b1);
    chk("R2 still on before limit", port_ready, {NP{1'b1}});
    cyc('0, '0, '0, '0, 1'b1);
    chk("R2 off after limit+1 idle", port_pwr_en, '0);
    chk("R7 router gated", router_clk_en, 0);
    cyc('0, '0, 5'b10101, 5'b01010, 1'b1);    // R11 route signals do not wake

    // R5 R8: wake port 2, latency 2; R6 repeated request while waking
    cyc('0, 5'b00100, '0, '0, 1'b1);
    cyc('0, 5'b00100, '0, '0, 1'b1);
    chk("R5 ready after wake latency", port_ready[2], 1);
    chk("R12 other ports untouched", port_pwr_en[0], 0);

    // R5 zero latency
    wake_cycles = 3'd0;
    cyc(5'b00001, '0, '0, '0, 1'b1);
    chk("R5 zero latency ready", port_ready[0], 1);

    // R3: flit restarts the idle run on port 0
    wake_cycles = 3'd5;
    cyc('0, '0, '0, '0, 1'b0);
    cyc('0, '0, '0, '0, 1'b0);
    cyc(5'b00001, '0, '0, '0, 1'b0);
    cyc('0, '0, '0, '0, 1'b0);
    cyc('0, '0, '0, '0, 1'b0);
    cyc('0, '0, '0, '0, 1'b0);
    chk("R3 restart keeps port on", port_ready[0], 1);
    cyc('0, '0, '0, '0, 1'b0);
    chk("R7 not gated while not empty", router_clk_en, 1);
    repeat (6) cyc('0, '0, '0, '0, 1'b0);

    // R6 R5: long wake with repeated requests
    cyc('0, 5'b11111, '0, '0, 1'b1);
    repeat (3) cyc('0, 5'b00011, '0, '0, 1'b1);
    chk("R6 not ready mid wake", port_ready[0], 0);
    cyc('0, '0, '0, '0, 1'b1);
    chk("R6 ready at wake end", port_ready[0], 1);

    // random traffic for R2 to R12
    for (int i = 0; i < 4000; i++) begin
      logic [NP-1:0] f, w, nd, nr;
      if (i % 250 == 0) begin
        idle_limit  = CW'($urandom_range(0, 7));
        wake_cycles = WW'($urandom_range(0, 7));
      end
      for (int p = 0; p < NP; p++) begin
        f[p]  = ($urandom_range(0, 99) < 12);
        w[p]  = ($urandom_range(0, 99) < 4);
        nd[p] = $urandom_range(0, 1);
        nr[p] = $urandom_range(0, 1);
      end
      cyc(f, w, nd, nr, logic'($urandom_range(0, 3) != 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule